// File: doc/BRIEF.md
# Real-time clock register interface

This block sits between a processor's narrow asynchronous bus and the timekeeping core of a real-time clock. The processor drives a 4-bit address, a 4-bit data bus and three active-low strobes (chip select, read, write). The block brings every strobe, address and data pin into the system clock domain through a synchroniser chain, then decodes sixteen locations. Location 0 is the control location: a write loads four control latches that steer the clock core, and a read returns two status flags. Location 15 is shared by the clock-setting register and the interval-timer configuration register, and a control latch chooses which of them is reached. Locations 1 to 14 are forwarded to the time counters, which are outside this block, as are the interval timer and the oscillator.

The block keeps a data-changed flag, set by each time-update tick, and an interrupt flag, set by each timer timeout. Both clear when a control read ends. While a control read is in progress, the flags it returns stay frozen. A tick that lands inside that read is discarded. A timeout that lands inside it is held back and raises the interrupt once the read has finished. The strobe bus has no back-pressure. Every access completes within a fixed number of system clocks after the strobes change, and the block never stalls the processor.

Top module: `rtc_bus_if`

## Requirements
- R1: A write is the span in which the synchronised chip select and write are both low. It takes effect once, when the first of them returns high, using the last address and data seen during the span. A later change on the data pins has no effect.
- R2: A write to location 0 loads the control latches from data bits 3..0 as test_mode, clk_stop, bank_sel and tmr_stop. Reset leaves them at 0, 1, 0 and 1.
- R3: A read of location 0 returns the data-changed flag on bit 3, zeros on bits 2 and 1, and the interrupt flag on bit 0.
- R4: Location 15 reaches the clock-setting register (set_wr, set_rdata) when bank_sel is 0, and the timer configuration register (icfg_wr, icfg_rdata) when bank_sel is 1. A write pulses exactly one of the strobe outputs.
- R5: A write to locations 2..14 pulses tim_wr for one clock, with tim_waddr and tim_wdata valid in that clock. A write to location 1 produces no pulse.
- R6: A read of locations 1..14 returns tim_rdata masked to the implemented width of that location. Locations 1, 2, 4, 6, 8, 10, 12 and 13 have 4 bits. Locations 3, 5 and 14 have 3 bits. Locations 7 and 9 have 2 bits. Location 11 has 1 bit.
- R7: Each tick sets the data-changed flag. Reads and writes of other locations, and writes to location 0, leave it set.
- R8: Both flags clear when a control read ends, and they keep their values for the whole read.
- R9: A tick that arrives during a control read, including its closing clock, does not set the data-changed flag.
- R10: A timeout that arrives during a control read is stored. irq_n stays high until the read has ended and then goes low.
- R11: A write to the timer configuration register whose bits 2..0 are 000 sets tmr_stop to 1.
- R12: bus_rdata_oe is high exactly while the synchronised read strobe (chip select and read both low) is active. bus_rdata is 0 whenever bus_rdata_oe is low.
- R13: irq_n is low exactly while the interrupt flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_addr | input | 4 | Register location |
| bus_wdata | input | 4 | Write data from processor |
| bus_rdata | output | 4 | Read data to the pad driver |
| bus_rdata_oe | output | 1 | Pad output enable; bus floats when low |
| test_mode | output | 1 | Control latch: test mode |
| clk_stop | output | 1 | Control latch: halt timekeeping |
| bank_sel | output | 1 | Control latch: location 15 bank select |
| tmr_stop | output | 1 | Control latch: halt interval timer |
| tick | input | 1 | One-clock time-update event |
| timeout | input | 1 | One-clock interval-timer expiry event |
| irq_n | output | 1 | Interrupt request, active low |
| tim_raddr | output | 4 | Location being read from the counters |
| tim_rdata | input | 4 | Counter value at tim_raddr |
| tim_wr | output | 1 | Counter write pulse |
| tim_waddr | output | 4 | Counter write location |
| tim_wdata | output | 4 | Write data for counters and location-15 registers |
| set_wr | output | 1 | Clock-setting register write pulse |
| set_rdata | input | 4 | Clock-setting register value |
| icfg_wr | output | 1 | Timer configuration register write pulse |
| icfg_rdata | input | 4 | Timer configuration register value |

## Verification
The hardest situation to reach from the ports is an event that falls inside a control read. It has to land in the short window after the synchronised read strobe opens and before it closes, and that window sits two clocks behind the pins. The stimulus holds chip select and read low for a fixed number of clocks. It then injects a one-clock tick or timeout at a cycle counted from the synchroniser depth, so the event falls in the middle of the window. A reference model steps every clock alongside the design, so the frozen flags, the discarded tick and the late interrupt are all compared clock by clock as well as by directed reads.

// File: rtl/rtc_bus_pkg.sv
package rtc_bus_pkg;
  localparam int RB_AW = 4;
  localparam int RB_DW = 4;

  localparam logic [RB_AW-1:0] LOC_CTRL   = 4'd0;
  localparam logic [RB_AW-1:0] LOC_TENTHS = 4'd1;
  localparam logic [RB_AW-1:0] LOC_BANK   = 4'd15;

  // Field order follows the data-bit positions of a control write.
  typedef struct packed {
    logic test;
    logic clk_stop;
    logic bank_sel;
    logic tmr_stop;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{test: 1'b0, clk_stop: 1'b1, bank_sel: 1'b0, tmr_stop: 1'b1};

  // Bits actually held by each counter location.
  function automatic logic [RB_DW-1:0] impl_mask(input logic [RB_AW-1:0] loc);
    logic [RB_DW-1:0] m;
    case (loc)
      4'd3, 4'd5, 4'd14: m = 4'b0111;
      4'd7, 4'd9:        m = 4'b0011;
      4'd11:             m = 4'b0001;
      4'd0, 4'd15:       m = 4'b0000;
      default:           m = 4'b1111;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/rtc_bus_sync.sv
module rtc_bus_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (STAGES < 2) begin : g_one
      logic [W-1:0] r;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) r <= RST_VAL;
        else        r <= d;
      assign q = r;
    end else begin : g_chain
      logic [STAGES*W-1:0] chain;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[(STAGES-1)*W-1:0], d};
      assign q = chain[STAGES*W-1 -: W];
    end
  endgenerate
endmodule

// File: rtl/rtc_strobe_decode.sv
module rtc_strobe_decode #(
  parameter int AW = 4,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_s,
  input  logic          rd_s,
  input  logic          wr_s,
  input  logic [AW-1:0] addr_s,
  input  logic [DW-1:0] data_s,
  output logic          wr_commit,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          rd_active,
  output logic          ctl_now,
  output logic          ctl_end
);
  logic ws, ws_q, rs_q, ctl_hold;

  assign ws        = !cs_s && !wr_s;
  assign rd_active = !cs_s && !rd_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_q     <= 1'b0;
      rs_q     <= 1'b0;
      ctl_hold <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      ws_q     <= ws;
      rs_q     <= rd_active;
      ctl_hold <= ctl_now;
      if (ws) begin
        wr_addr <= addr_s;
        wr_data <= data_s;
      end
    end
  end

  // Trailing edge of the write span: values last seen inside it are used.
  assign wr_commit = ws_q && !ws;
  // A read is classed as a control read from its first synchronised clock.
  assign ctl_now   = rd_active && (rs_q ? ctl_hold : (addr_s == '0));
  assign ctl_end   = ctl_hold && !rd_active;
endmodule

// File: rtl/rtc_status_flags.sv
module rtc_status_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic timeout,
  input  logic ctl_now,
  input  logic ctl_end,
  output logic dcf,
  output logic irq_flag
);
  logic irq_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcf      <= 1'b0;
      irq_flag <= 1'b0;
      irq_pend <= 1'b0;
    end else if (ctl_end) begin
      dcf      <= 1'b0;
      irq_flag <= irq_pend || timeout;
      irq_pend <= 1'b0;
    end else if (ctl_now) begin
      irq_pend <= irq_pend || timeout;
    end else begin
      dcf      <= dcf || tick;
      irq_flag <= irq_flag || timeout;
    end
  end
endmodule

// File: rtl/rtc_bus_if.sv
module rtc_bus_if
  import rtc_bus_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_cs_n,
  input  logic             bus_rd_n,
  input  logic             bus_wr_n,
  input  logic [RB_AW-1:0] bus_addr,
  input  logic [RB_DW-1:0] bus_wdata,
  output logic [RB_DW-1:0] bus_rdata,
  output logic             bus_rdata_oe,
  output logic             test_mode,
  output logic             clk_stop,
  output logic             bank_sel,
  output logic             tmr_stop,
  input  logic             tick,
  input  logic             timeout,
  output logic             irq_n,
  output logic [RB_AW-1:0] tim_raddr,
  input  logic [RB_DW-1:0] tim_rdata,
  output logic             tim_wr,
  output logic [RB_AW-1:0] tim_waddr,
  output logic [RB_DW-1:0] tim_wdata,
  output logic             set_wr,
  input  logic [RB_DW-1:0] set_rdata,
  output logic             icfg_wr,
  input  logic [RB_DW-1:0] icfg_rdata
);
  localparam int SW = 3 + RB_AW + RB_DW;
  localparam logic [SW-1:0] SYNC_IDLE = {3'b111, {(RB_AW + RB_DW){1'b0}}};

  logic [SW-1:0]    pins_s;
  logic             cs_s, rd_s, wr_s;
  logic [RB_AW-1:0] addr_s;
  logic [RB_DW-1:0] data_s;
  logic             wr_commit, rd_active, ctl_now, ctl_end;
  logic [RB_AW-1:0] wr_addr;
  logic [RB_DW-1:0] wr_data;
  logic             dcf, irq_flag;
  logic [RB_DW-1:0] rd_mux;
  ctrl_t            ctrl;

  rtc_bus_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_IDLE)) i_sync (
    .clk(clk), .rst_n(rst_n),
    .d({bus_cs_n, bus_rd_n, bus_wr_n, bus_addr, bus_wdata}),
    .q(pins_s)
  );

  assign cs_s   = pins_s[SW-1];
  assign rd_s   = pins_s[SW-2];
  assign wr_s   = pins_s[SW-3];
  assign addr_s = pins_s[RB_AW+RB_DW-1:RB_DW];
  assign data_s = pins_s[RB_DW-1:0];

  rtc_strobe_decode #(.AW(RB_AW), .DW(RB_DW)) i_dec (
    .clk(clk), .rst_n(rst_n),
    .cs_s(cs_s), .rd_s(rd_s), .wr_s(wr_s), .addr_s(addr_s), .data_s(data_s),
    .wr_commit(wr_commit), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_active(rd_active), .ctl_now(ctl_now), .ctl_end(ctl_end)
  );

  rtc_status_flags i_flags (
    .clk(clk), .rst_n(rst_n), .tick(tick), .timeout(timeout),
    .ctl_now(ctl_now), .ctl_end(ctl_end), .dcf(dcf), .irq_flag(irq_flag)
  );

  // Write routing
  assign tim_wr    = wr_commit && (wr_addr != LOC_CTRL) && (wr_addr != LOC_TENTHS)
                     && (wr_addr != LOC_BANK);
  assign set_wr    = wr_commit && (wr_addr == LOC_BANK) && !ctrl.bank_sel;
  assign icfg_wr   = wr_commit && (wr_addr == LOC_BANK) && ctrl.bank_sel;
  assign tim_waddr = wr_addr;
  assign tim_wdata = wr_data;

  // Control latches
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ctrl <= CTRL_RST;
    else if (wr_commit && wr_addr == LOC_CTRL)
      ctrl <= ctrl_t'(wr_data);
    else if (icfg_wr && wr_data[2:0] == 3'b000)
      ctrl.tmr_stop <= 1'b1;
  end

  assign test_mode = ctrl.test;
  assign clk_stop  = ctrl.clk_stop;
  assign bank_sel  = ctrl.bank_sel;
  assign tmr_stop  = ctrl.tmr_stop;

  // Read path
  assign tim_raddr = addr_s;

  always_comb begin
    if (addr_s == LOC_CTRL)
      rd_mux = {dcf, 2'b00, irq_flag};
    else if (addr_s == LOC_BANK)
      rd_mux = ctrl.bank_sel ? icfg_rdata : set_rdata;
    else
      rd_mux = tim_rdata & impl_mask(addr_s);
  end

  assign bus_rdata    = rd_active ? rd_mux : '0;
  assign bus_rdata_oe = rd_active;
  assign irq_n        = !irq_flag;
endmodule

// File: rtl/rtc_bus_if_chk.sv
module rtc_bus_if_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tim_wr,
  input logic [3:0] tim_waddr,
  input logic [3:0] tim_wdata,
  input logic       set_wr,
  input logic       icfg_wr,
  input logic       test_mode,
  input logic       clk_stop,
  input logic       bank_sel,
  input logic       tmr_stop,
  input logic       irq_n,
  input logic       wr_commit,
  input logic [3:0] wr_addr,
  input logic [3:0] wr_data,
  input logic       ctl_now,
  input logic       ctl_end,
  input logic       dcf,
  input logic       irq_flag
);
  a_r5_pulse_once: assert property (@(posedge clk) disable iff (!rst_n)
    tim_wr |=> !tim_wr);

  a_r5_no_tenths: assert property (@(posedge clk) disable iff (!rst_n)
    tim_wr |-> (tim_waddr != 4'd1 && tim_waddr != 4'd0 && tim_waddr != 4'd15));

  a_r4_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tim_wr, set_wr, icfg_wr}));

  a_r2_ctrl_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_commit && wr_addr == 4'd0) |=> ({test_mode, clk_stop, bank_sel, tmr_stop} == $past(wr_data)));

  a_r11_auto_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (icfg_wr && tim_wdata[2:0] == 3'b000) |=> tmr_stop);

  a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_now && $past(ctl_now)) |-> ($stable(dcf) && $stable(irq_flag)));

  a_r7_clear_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dcf) |-> $past(ctl_end));

  a_r9_no_set_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dcf) |-> (!$past(ctl_now) && !$past(ctl_end)));

  a_r10_irq_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> !$past(ctl_now));
endmodule

bind rtc_bus_if rtc_bus_if_chk i_chk (
  .clk(clk), .rst_n(rst_n),
  .tim_wr(tim_wr), .tim_waddr(tim_waddr), .tim_wdata(tim_wdata),
  .set_wr(set_wr), .icfg_wr(icfg_wr),
  .test_mode(test_mode), .clk_stop(clk_stop), .bank_sel(bank_sel), .tmr_stop(tmr_stop),
  .irq_n(irq_n), .wr_commit(wr_commit), .wr_addr(wr_addr), .wr_data(wr_data),
  .ctl_now(ctl_now), .ctl_end(ctl_end), .dcf(dcf), .irq_flag(irq_flag)
);

// File: tb/test_rtc_bus_if.sv
module test_rtc_bus_if;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [3:0] addr = '0, wdata = '0;
  logic tick = 1'b0, timeout = 1'b0;
  logic [3:0] bus_rdata, tim_raddr, tim_waddr, tim_wdata;
  logic [3:0] tim_rdata;
  logic bus_rdata_oe, test_mode, clk_stop, bank_sel, tmr_stop, irq_n;
  logic tim_wr, set_wr, icfg_wr;
  logic [3:0] store [16];
  logic [3:0] set_reg = 4'hA, icfg_reg = 4'h0;
  int checks = 0, fails = 0, cycles = 0;
  bit run = 0, done = 0;

  always #4 clk = ~clk;

  rtc_bus_if i_rtc_bus_if (
    .clk(clk), .rst_n(rst_n), .bus_cs_n(cs_n), .bus_rd_n(rd_n), .bus_wr_n(wr_n),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(bus_rdata), .bus_rdata_oe(bus_rdata_oe),
    .test_mode(test_mode), .clk_stop(clk_stop), .bank_sel(bank_sel), .tmr_stop(tmr_stop),
    .tick(tick), .timeout(timeout), .irq_n(irq_n),
    .tim_raddr(tim_raddr), .tim_rdata(tim_rdata), .tim_wr(tim_wr), .tim_waddr(tim_waddr),
    .tim_wdata(tim_wdata), .set_wr(set_wr), .set_rdata(set_reg), .icfg_wr(icfg_wr),
    .icfg_rdata(icfg_reg)
  );

  // Counter and bank register stand-ins
  assign tim_rdata = store[tim_raddr];
  initial begin
    for (int i = 0; i < 16; i++) store[i] = 4'hF;
    store[1] = 4'h6;
  end
  always @(posedge clk) begin
    if (tim_wr)  store[tim_waddr] <= tim_wdata;
    if (set_wr)  set_reg  <= tim_wdata;
    if (icfg_wr) icfg_reg <= tim_wdata;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] width_mask(input logic [3:0] a);
    int w;
    w = 4;
    if (a == 3 || a == 5 || a == 14) w = 3;
    if (a == 7 || a == 9) w = 2;
    if (a == 11) w = 1;
    if (a == 0 || a == 15) w = 0;
    return 4'((1 << w) - 1);
  endfunction

  // Behavioural reference model, stepped on every clock
  logic [10:0] pq [$];
  bit m_wsq, m_rsq, m_hold, m_dcf, m_irq, m_pend;
  logic [3:0] m_capa, m_capd, m_ctrl;

  always @(posedge clk) begin : model
    logic [10:0] v;
    bit ws, rs, commit, cnow, cend;
    cycles++;
    if (!rst_n) begin
      pq = {11'h700, 11'h700};
      m_wsq = 0; m_rsq = 0; m_hold = 0; m_dcf = 0; m_irq = 0; m_pend = 0;
      m_capa = 0; m_capd = 0; m_ctrl = 4'b0101;
    end else begin
      v = pq[0];
      ws = !v[10] && !v[8];
      rs = !v[10] && !v[9];
      commit = m_wsq && !ws;
      cnow = rs && (m_rsq ? m_hold : (v[7:4] == 0));
      cend = m_hold && !rs;
      if (commit && m_capa == 0) m_ctrl = m_capd;
      else if (commit && m_capa == 15 && m_ctrl[1] && m_capd[2:0] == 0) m_ctrl[0] = 1'b1;
      if (cend) begin m_dcf = 0; m_irq = m_pend | timeout; m_pend = 0; end
      else if (cnow) m_pend = m_pend | timeout;
      else begin m_dcf = m_dcf | tick; m_irq = m_irq | timeout; end
      m_wsq = ws;
      if (ws) begin m_capa = v[7:4]; m_capd = v[3:0]; end
      m_rsq = rs;
      m_hold = cnow;
      pq.push_back({cs_n, rd_n, wr_n, addr, wdata});
      void'(pq.pop_front());
    end
  end

  always @(negedge clk) begin : compare
    logic [10:0] v;
    logic [3:0] er, a;
    bit ws, rs, commit;
    if (rst_n && run && !done) begin
      v = pq[0];
      a = v[7:4];
      ws = !v[10] && !v[8];
      rs = !v[10] && !v[9];
      commit = m_wsq && !ws;
      check({test_mode, clk_stop, bank_sel, tmr_stop} == m_ctrl, "R2 latches",
            {test_mode, clk_stop, bank_sel, tmr_stop}, m_ctrl);
      check(irq_n == !m_irq, "R13 irq_n", irq_n, !m_irq);
      check(bus_rdata_oe == rs, "R12 oe", bus_rdata_oe, rs);
      if (!rs) er = 0;
      else if (a == 0) er = {m_dcf, 2'b00, m_irq};
      else if (a == 15) er = m_ctrl[1] ? icfg_reg : set_reg;
      else er = store[a] & width_mask(a);
      check(bus_rdata == er, !rs ? "R12 idle data" : (a == 0 ? "R3 status" : (a == 15 ? "R4 bank read" : "R6 counter read")),
            bus_rdata, er);
      check(tim_wr == (commit && m_capa >= 2 && m_capa <= 14), "R5 tim_wr", tim_wr,
            commit && m_capa >= 2 && m_capa <= 14);
      if (tim_wr) check({tim_waddr, tim_wdata} == {m_capa, m_capd}, "R1 write capture",
                        {tim_waddr, tim_wdata}, {m_capa, m_capd});
      check(set_wr == (commit && m_capa == 15 && !m_ctrl[1]), "R4 set_wr", set_wr,
            commit && m_capa == 15 && !m_ctrl[1]);
      check(icfg_wr == (commit && m_capa == 15 && m_ctrl[1]), "R4 icfg_wr", icfg_wr,
            commit && m_capa == 15 && m_ctrl[1]);
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [3:0] d, input int late);
    addr = a; wdata = d; cs_n = 0; wr_n = 0;
    step(3);
    wr_n = 1; cs_n = 1;
    if (late >= 0) wdata = 4'(late);
    step(5);
  endtask

  // ev: 0 none, 1 tick, 2 timeout, pulsed in the middle of the read window
  task automatic bus_read(input logic [3:0] a, input int ev, output logic [3:0] v, output logic irq_mid);
    addr = a; cs_n = 0; rd_n = 0;
    step(3);
    if (ev == 1) tick = 1;
    if (ev == 2) timeout = 1;
    step(1);
    tick = 0; timeout = 0;
    step(1);
    @(negedge clk);
    v = bus_rdata;
    irq_mid = irq_n;
    step(1);
    cs_n = 1; rd_n = 1;
    step(4);
  endtask

  task automatic pulse(input bit is_tick);
    if (is_tick) tick = 1; else timeout = 1;
    step(1);
    tick = 0; timeout = 0;
    step(2);
  endtask

  initial begin : watchdog
    wait (cycles > 50000);
    if (!done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, 50000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : stim
    logic [3:0] v;
    logic im;
    step(3);
    rst_n = 1;
    run = 1;
    step(2);
    check({test_mode, clk_stop, bank_sel, tmr_stop} == 4'b0101, "R2 reset latches",
          {test_mode, clk_stop, bank_sel, tmr_stop}, 4'b0101);
    check(irq_n == 1, "R13 reset irq_n", irq_n, 1);
    check(bus_rdata_oe == 0 && bus_rdata == 0, "R12 reset bus", bus_rdata_oe, 0);

    bus_write(4'd0, 4'd0, -1);
    check({test_mode, clk_stop, bank_sel, tmr_stop} == 4'b0000, "R2 clear latches",
          {test_mode, clk_stop, bank_sel, tmr_stop}, 0);

    // R1: data changed after the span is ignored
    bus_write(4'd4, 4'd9, 2);
    bus_read(4'd4, 0, v, im);
    check(v == 4'd9, "R1 data latched in span", v, 9);
    // R5 / R6
    bus_write(4'd3, 4'd5, -1);
    bus_read(4'd3, 0, v, im);
    check(v == 4'd5, "R5 counter write", v, 5);
    bus_write(4'd1, 4'd9, -1);
    bus_read(4'd1, 0, v, im);
    check(v == 4'd6, "R5 tenths read-only", v, 6);
    bus_read(4'd7, 0, v, im);
    check(v == 4'd3, "R6 two-bit mask", v, 3);
    bus_read(4'd11, 0, v, im);
    check(v == 4'd1, "R6 one-bit mask", v, 1);
    bus_read(4'd14, 0, v, im);
    check(v == 4'd7, "R6 three-bit mask", v, 7);

    // R4 / R11 bank at location 15
    bus_read(4'd15, 0, v, im);
    check(v == 4'hA, "R4 setting bank read", v, 4'hA);
    bus_write(4'd0, 4'b0010, -1);
    bus_read(4'd15, 0, v, im);
    check(v == 4'h0, "R4 config bank read", v, 0);
    bus_write(4'd15, 4'b1011, -1);
    bus_read(4'd15, 0, v, im);
    check(v == 4'hB && set_reg == 4'hA, "R4 config write", v, 4'hB);
    check(tmr_stop == 0, "R11 nonzero delay keeps run", tmr_stop, 0);
    bus_write(4'd15, 4'b1000, -1);
    check(tmr_stop == 1, "R11 zero delay forces stop", tmr_stop, 1);
    bus_write(4'd0, 4'b1100, -1);
    check({test_mode, clk_stop, bank_sel, tmr_stop} == 4'b1100, "R2 load latches",
          {test_mode, clk_stop, bank_sel, tmr_stop}, 4'b1100);
    bus_read(4'd15, 0, v, im);
    check(v == 4'hA, "R4 back to setting bank", v, 4'hA);
    bus_write(4'd0, 4'd0, -1);

    // R7 / R8 data-changed flag
    pulse(1);
    bus_read(4'd3, 0, v, im);
    bus_write(4'd5, 4'd1, -1);
    bus_write(4'd0, 4'd0, -1);
    bus_read(4'd0, 0, v, im);
    check(v == 4'b1000, "R7 flag survives other access", v, 4'b1000);
    bus_read(4'd0, 0, v, im);
    check(v == 4'b0000, "R8 cleared by control read", v, 0);

    // R9 tick inside control read
    bus_read(4'd0, 1, v, im);
    check(v == 4'b0000, "R9 value during read", v, 0);
    bus_read(4'd0, 0, v, im);
    check(v == 4'b0000, "R9 tick in read discarded", v, 0);

    // R10 timeout inside control read
    bus_read(4'd0, 2, v, im);
    check(v == 4'b0000 && im == 1, "R10 held during read", {v, im}, 5'b00001);
    check(irq_n == 0, "R10 irq after read", irq_n, 0);
    bus_read(4'd0, 0, v, im);
    check(v == 4'b0001, "R10 deferred flag", v, 1);
    check(irq_n == 1, "R8 irq cleared by read", irq_n, 1);

    // R3 both flags
    pulse(1);
    pulse(0);
    check(irq_n == 0, "R13 irq asserted", irq_n, 0);
    bus_read(4'd0, 0, v, im);
    check(v == 4'b1001, "R3 status layout", v, 4'b1001);
    bus_read(4'd0, 0, v, im);
    check(v == 4'b0000, "R8 both cleared", v, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule